// File: doc/BRIEF.md
# Capability Indirect Jump Checker

This block sits in the execute stage of a capability-extended RISC-V core, beside the branch unit. For one register-indirect jump-and-link it works out where control goes and whether the jump may go there. The inputs are the decoded fields of the source capability, the 12-bit jump immediate, the current program counter and the minimum instruction length the core supports. The outputs are the target address and sealed state, the return link address and its sealed state, and a single exception report with a cause code.

When the immediate is zero, the source capability is unsealed and its address is used as it is. A nonzero immediate offsets the address and leaves the seal alone. Offsetting a sealed capability is itself a violation. Bit 0 of the target is always cleared.

The four checks run side by side and a fixed priority picks one of them to report. The block is purely combinational and holds no state. It takes one decision per evaluation, so it has no valid/ready pair: the surrounding pipeline stage owns flow control and back-pressure.

Top module: `cjmp_check`

## Requirements
- R1: With a zero immediate, `tgt_addr` equals `src_addr` with bit 0 cleared and `tgt_sealed` is 0.
- R2: With a nonzero immediate, `tgt_addr` is `src_addr` plus the sign-extended immediate, modulo 2^XLEN, with bit 0 cleared. `tgt_sealed` then equals `src_sealed`.
- R3: Bit 0 of `tgt_addr` is always 0, and the bounds check uses this cleared address.
- R4: `link_addr` is `cur_pc + 4` modulo 2^XLEN, and `link_sealed` is 1.
- R5: A clear `src_tag` reports cause code 1 (tag violation).
- R6: With the tag set, a sealed source together with a nonzero immediate reports cause code 2 (seal violation). A sealed source with a zero immediate raises no seal violation.
- R7: With the tag set and no seal violation, a clear `src_exec` reports cause code 3 (permission violation).
- R8: With all earlier checks passing, cause code 4 (length violation) is reported when `tgt_addr < src_base` or `tgt_addr + min_len > src_top`. `src_top` is XLEN+1 bits wide, so a top of 2^XLEN can be expressed, and the sum is formed without overflow.
- R9: When every check passes, `exc_valid` is 0 and both `exc_cause` and `exc_kind` are 0. Otherwise `exc_valid` is 1 and `exc_kind` is 1, the jump exception kind.
- R10: When several checks fail, only the first one in the order tag, seal, permission, length is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_tag | input | 1 | Source capability tag |
| src_sealed | input | 1 | Source capability is sealed |
| src_exec | input | 1 | Source capability grants execute |
| src_addr | input | XLEN | Source capability address |
| src_base | input | XLEN | Decoded lower bound |
| src_top | input | XLEN+1 | Decoded upper bound (exclusive) |
| jmp_imm | input | IMM_W | Jump immediate |
| cur_pc | input | XLEN | Address of the jump |
| min_len | input | LEN_W | Minimum instruction length in bytes |
| tgt_addr | output | XLEN | Jump target address |
| tgt_sealed | output | 1 | Target capability sealed state |
| link_addr | output | XLEN | Return address |
| link_sealed | output | 1 | Link capability sealed state |
| exc_valid | output | 1 | Jump raises an exception |
| exc_cause | output | 3 | Cause code (0 none, 1 tag, 2 seal, 3 permission, 4 length) |
| exc_kind | output | 2 | Exception kind (1 jump, 0 when none) |

## Verification
The embedded assertions assume the decoded bounds are well formed (`src_base` no greater than `src_top`) and that `min_len` is a legal nonzero instruction size. The bench builds the block with an 8-bit address and keeps to those limits throughout. It sweeps every address against base/top pairs that sit on and next to the target, including a top of 2^XLEN. It uses immediates that wrap the address in both directions, both instruction lengths, and all eight combinations of tag, seal and execute.

// File: rtl/cjmp_pkg.sv
package cjmp_pkg;
  localparam int CAUSE_W = 3;
  localparam int KIND_W  = 2;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_TAG  = 3'd1,
    CAUSE_SEAL = 3'd2,
    CAUSE_PERM = 3'd3,
    CAUSE_LEN  = 3'd4
  } cause_e;

  localparam logic [KIND_W-1:0] KIND_NONE = 2'd0;
  localparam logic [KIND_W-1:0] KIND_JUMP = 2'd1;

  // fault vector index = priority (0 highest); cause code = index + 1
  localparam int N_CHECKS = 4;
  localparam int IDX_TAG  = 0;
  localparam int IDX_SEAL = 1;
  localparam int IDX_PERM = 2;
  localparam int IDX_LEN  = 3;
endpackage

// File: rtl/cjmp_target.sv
module cjmp_target #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 12
) (
  input  logic [XLEN-1:0]  src_addr,
  input  logic [IMM_W-1:0] imm,
  input  logic             src_sealed,
  output logic [XLEN-1:0]  tgt_addr,
  output logic             tgt_sealed,
  output logic             imm_nz
);
  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] moved;
  logic [XLEN-1:0] chosen;

  always_comb begin
    imm_nz     = |imm;
    offset     = XLEN'($signed(imm));
    moved      = src_addr + offset;
    chosen     = imm_nz ? moved : src_addr;
    tgt_addr   = {chosen[XLEN-1:1], 1'b0};
    tgt_sealed = src_sealed & imm_nz;
  end

  // R1: zero immediate keeps the address and unseals
  always_comb begin
    if (!(|imm)) begin
      a_r1_zero_imm_unseal: assert (tgt_addr[XLEN-1:1] == src_addr[XLEN-1:1] && !tgt_sealed);
    end
  end
endmodule

// File: rtl/cjmp_bounds.sv
module cjmp_bounds #(
  parameter int XLEN  = 32,
  parameter int LEN_W = 3
) (
  input  logic [XLEN-1:0]  tgt_addr,
  input  logic [XLEN-1:0]  base,
  input  logic [XLEN:0]    top,
  input  logic [LEN_W-1:0] min_len,
  output logic             out_of_bounds
);
  localparam int WIDE = XLEN + 1;

  logic [WIDE-1:0] end_addr;
  logic            below;
  logic            above;

  always_comb begin
    end_addr      = {1'b0, tgt_addr} + WIDE'(min_len);
    below         = tgt_addr < base;
    above         = end_addr > top;
    out_of_bounds = below | above;
  end
endmodule

// File: rtl/cjmp_prio.sv
module cjmp_prio #(
  parameter int N  = 4,
  parameter int CW = 3
) (
  input  logic [N-1:0]  fault,
  output logic [N-1:0]  grant,
  output logic [CW-1:0] code
);
  for (genvar i = 0; i < N; i++) begin : g_grant
    if (i == 0) begin : g_first
      assign grant[i] = fault[i];
    end else begin : g_rest
      assign grant[i] = fault[i] & ~(|fault[i-1:0]);
    end
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) code = CW'(i + 1);
    end
  end

  // R10: at most one check is reported
  always_comb begin
    a_r10_single_grant: assert ($onehot0(grant));
  end
endmodule

// File: rtl/cjmp_check.sv
module cjmp_check
  import cjmp_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int IMM_W    = 12,
  parameter int LEN_W    = 3,
  parameter int LINK_INC = 4
) (
  input  logic               src_tag,
  input  logic               src_sealed,
  input  logic               src_exec,
  input  logic [XLEN-1:0]    src_addr,
  input  logic [XLEN-1:0]    src_base,
  input  logic [XLEN:0]      src_top,
  input  logic [IMM_W-1:0]   jmp_imm,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic [LEN_W-1:0]   min_len,
  output logic [XLEN-1:0]    tgt_addr,
  output logic               tgt_sealed,
  output logic [XLEN-1:0]    link_addr,
  output logic               link_sealed,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [KIND_W-1:0]  exc_kind
);
  logic                imm_nz;
  logic                oob;
  logic [N_CHECKS-1:0] fault;
  logic [N_CHECKS-1:0] grant;

  cjmp_target #(.XLEN(XLEN), .IMM_W(IMM_W)) u_target (
    .src_addr  (src_addr),
    .imm       (jmp_imm),
    .src_sealed(src_sealed),
    .tgt_addr  (tgt_addr),
    .tgt_sealed(tgt_sealed),
    .imm_nz    (imm_nz)
  );

  cjmp_bounds #(.XLEN(XLEN), .LEN_W(LEN_W)) u_bounds (
    .tgt_addr     (tgt_addr),
    .base         (src_base),
    .top          (src_top),
    .min_len      (min_len),
    .out_of_bounds(oob)
  );

  always_comb begin
    fault           = '0;
    fault[IDX_TAG]  = ~src_tag;
    fault[IDX_SEAL] = src_sealed & imm_nz;
    fault[IDX_PERM] = ~src_exec;
    fault[IDX_LEN]  = oob;
  end

  cjmp_prio #(.N(N_CHECKS), .CW(CAUSE_W)) u_prio (
    .fault(fault),
    .grant(grant),
    .code (exc_cause)
  );

  always_comb begin
    exc_valid   = |fault;
    exc_kind    = exc_valid ? KIND_JUMP : KIND_NONE;
    link_addr   = cur_pc + XLEN'(LINK_INC);
    link_sealed = 1'b1;
  end

  // R9: exception flag agrees with the encoded cause
  always_comb begin
    a_r9_valid_matches_cause: assert (exc_valid == (exc_cause != CAUSE_NONE));
  end
  // R5: a clear tag always wins
  always_comb begin
    if (!src_tag) begin
      a_r5_tag_first: assert (exc_cause == CAUSE_TAG);
    end
  end
  // R6: a seal cause needs a sealed source and an offset
  always_comb begin
    if (exc_cause == CAUSE_SEAL) begin
      a_r6_seal_needs_offset: assert (src_sealed && (jmp_imm != '0) && src_tag);
    end
  end
  // R8: a length cause only when the earlier checks pass
  always_comb begin
    if (exc_cause == CAUSE_LEN) begin
      a_r8_len_last: assert (src_tag && src_exec && !tgt_sealed);
    end
  end
endmodule

// File: tb/tb_cjmp_check.sv
module tb_cjmp_check;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 8;
  localparam int IMM_W = 12;
  localparam int LEN_W = 3;
  localparam int WATCHDOG = 150000;
  localparam int MOD = 1 << XLEN;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             src_tag, src_sealed, src_exec;
  logic [XLEN-1:0]  src_addr, src_base, cur_pc, tgt_addr, link_addr;
  logic [XLEN:0]    src_top;
  logic [IMM_W-1:0] jmp_imm;
  logic [LEN_W-1:0] min_len;
  logic             tgt_sealed, link_sealed, exc_valid;
  logic [2:0]       exc_cause;
  logic [1:0]       exc_kind;

  cjmp_check #(.XLEN(XLEN), .IMM_W(IMM_W), .LEN_W(LEN_W)) dut (
    .src_tag(src_tag), .src_sealed(src_sealed), .src_exec(src_exec),
    .src_addr(src_addr), .src_base(src_base), .src_top(src_top),
    .jmp_imm(jmp_imm), .cur_pc(cur_pc), .min_len(min_len),
    .tgt_addr(tgt_addr), .tgt_sealed(tgt_sealed), .link_addr(link_addr),
    .link_sealed(link_sealed), .exc_valid(exc_valid),
    .exc_cause(exc_cause), .exc_kind(exc_kind)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    if (act != exp) begin
      n_bad++;
      if (n_bad < 20) $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input bit tag, input bit sl, input bit ex, input int addr,
                       input int base, input int top, input int imm, input int pc,
                       input int ml);
    int eimm, ta, link, cause;
    bit tsl;
    @(negedge clk);
    src_tag = tag; src_sealed = sl; src_exec = ex;
    src_addr = XLEN'(addr); src_base = XLEN'(base); src_top = (XLEN+1)'(top);
    jmp_imm = IMM_W'(imm); cur_pc = XLEN'(pc); min_len = LEN_W'(ml);
    #(CLK_PERIOD/4);
    eimm = imm & 12'hFFF;
    if (eimm >= 2048) eimm -= 4096;
    ta = (eimm == 0) ? addr : ((addr + eimm) % MOD + MOD) % MOD;
    ta = ta & ~1;
    tsl = sl && (eimm != 0);
    link = (pc + 4) % MOD;
    if (!tag) cause = 1;
    else if (tsl) cause = 2;
    else if (!ex) cause = 3;
    else if (ta < base || ta + ml > top) cause = 4;
    else cause = 0;
    n_vec++;
    chk(eimm == 0 ? "R1 target" : "R2 target", int'(tgt_addr), ta);
    chk("R3 bit0", int'(tgt_addr[0]), 0);
    chk(eimm == 0 ? "R1 sealed" : "R2 sealed", int'(tgt_sealed), int'(tsl));
    chk("R4 link", int'(link_addr), link);
    chk("R4 link_sealed", int'(link_sealed), 1);
    chk(cause == 1 ? "R5 cause" : cause == 2 ? "R6 cause" : cause == 3 ? "R7 cause" :
        cause == 4 ? "R8 cause" : "R10 cause", int'(exc_cause), cause);
    chk("R9 valid", int'(exc_valid), int'(cause != 0));
    chk("R9 kind", int'(exc_kind), cause != 0 ? 1 : 0);
  endtask

  initial begin
    int imms[8] = '{0, 1, -1, 2, -2, 2047, -2048, 130};
    int bases[4] = '{0, 16, 100, 200};
    int tops[4]  = '{256, 18, 101, 256};
    src_tag = 0; src_sealed = 0; src_exec = 0; src_addr = 0; src_base = 0;
    src_top = 0; jmp_imm = 0; cur_pc = 0; min_len = 0;
    repeat (3) @(posedge clk);
    // reset-state vector: all-zero inputs -> tag violation (R5)
    #1;
    n_vec++;
    chk("R5 reset cause", int'(exc_cause), 1);
    chk("R9 reset valid", int'(exc_valid), 1);
    rst = 1'b0;
    // R1 R2 R3 R8: every address vs bounds, legal flags
    for (int a = 0; a < MOD; a++)
      for (int i = 0; i < 8; i++)
        for (int b = 0; b < 4; b++)
          for (int m = 2; m <= 4; m += 2)
            apply(1, 0, 1, a, bases[b], tops[b], imms[i], a * 7 + i, m);
    // R5 R6 R7 R10: all flag combinations with and without offset
    for (int f = 0; f < 8; f++)
      for (int a = 0; a < MOD; a += 3)
        for (int i = 0; i < 3; i++)
          apply(f[0], f[1], f[2], a, 20, 60, imms[i], 252 + i, 4);
    // R4: pc wrap at the top of the address space
    for (int p = MOD - 8; p < MOD; p++) apply(1, 1, 1, 40, 0, 256, 0, p, 2);
    // R8: target exactly at top - min_len and one past
    apply(1, 0, 1, 252, 0, 256, 0, 0, 4);
    apply(1, 0, 1, 254, 0, 256, 0, 0, 4);
    apply(1, 0, 1, 10, 10, 12, 0, 0, 2);
    apply(1, 0, 1, 10, 10, 11, 0, 0, 2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule